// File: doc/BRIEF.md
# Masked Block and Flash Write Datapath

This block is the write side of a behavioural frame-buffer memory. It keeps a colour byte and a held plane-mask byte, and it owns a small array of rows and columns of 8-bit pixels. Every store into the array is gated plane by plane: each of the 8 bit planes is written only where the active mask bit is 1. There are three kinds of store. A single-pixel write takes its value from the data bus. A block fill copies the colour byte into up to four neighbouring columns, and the low data bits select which of those columns are written. A flash fill copies the colour byte into every column of a row in one command.

One command arrives per clock on a 4-bit opcode. A row is first opened, either plain or masked. Reads, pixel writes and block fills then act on that open row, and the page mask chosen when the row was opened stays in force until the next open. The page mask comes from the data bus when the held-mask input is 0 and from the held mask register when it is 1. A flash fill names its own row and chooses its mask in the same way, in that same cycle. Strobe timing, refresh and serial access are handled elsewhere.

Top module: `masked_fill_datapath`

## Requirements
- R1: After synchronous reset the colour register is 0x00, the held mask register is 0xFF, every array byte is 0x00 and rd_data_o is 0x00.
- R2: A read (opcode 3) places the byte at the open row and column col_i on rd_data_o at the clock edge that takes the command. rd_data_o holds its value until the next read.
- R3: A pixel write (opcode 4) stores data_i into the open row at column col_i, bit by bit under the page mask.
- R4: A mask bit of 1 lets the matching bit plane be written. A mask bit of 0 leaves the stored bit unchanged. This holds for pixel writes, block fills and flash fills.
- R5: Opening a masked row (opcode 2) with held_mask_i=0 takes data_i as the page mask. That mask stays in force for all later commands until the next open.
- R6: Opening a masked row with held_mask_i=1 takes the held mask register as the page mask, and data_i is ignored.
- R7: A colour load (opcode 7) and a mask load (opcode 8) capture data_i into the colour and held mask registers. The next command already sees the new value.
- R8: Opening a plain row (opcode 1) sets the page mask to all ones.
- R9: A block fill (opcode 5) ignores col_i[1:0] and uses the upper column bits to pick a group of 4 columns. data_i bit k enables column 4·group+k, and each enabled column receives the colour byte under the page mask.
- R10: A flash fill (opcode 6) writes the colour byte into every column of row row_i. The mask comes from data_i when held_mask_i=0 and from the held mask register when held_mask_i=1. The open row and the page mask are left unchanged.
- R11: Opcode 0 and opcodes 9 to 15 change no register, no array byte and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Command opcode |
| held_mask_i | input | 1 | 1 selects the held mask register instead of the bus |
| row_i | input | $clog2(ROWS) | Row for open and flash commands |
| col_i | input | $clog2(COLS) | Column for read, write and block commands |
| data_i | input | 8 | Pixel data, page mask, column enables or register value |
| rd_data_o | output | 8 | Registered read data |

## Verification
Two functions can meet at one clock edge. A colour or mask load can be followed at once by a block or flash fill, and the edge that takes the fill must already use the value loaded one edge earlier. A flash fill can also target the row that is currently open, so the same edge both rewrites that row and must leave the page mask in force. Directed sequences and a random mix of commands build these back-to-back pairs. A shadow model of the array and registers judges each read, and a full read sweep at the end judges the whole array.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
    localparam int PIX_W      = 8;
    localparam int BLOCK_COLS = 4;
    localparam int BLOCK_SH   = $clog2(BLOCK_COLS);

    typedef enum logic [3:0] {
        OP_IDLE        = 4'd0,
        OP_OPEN_PLAIN  = 4'd1,
        OP_OPEN_MASKED = 4'd2,
        OP_READ        = 4'd3,
        OP_WRITE       = 4'd4,
        OP_BLOCK       = 4'd5,
        OP_FLASH       = 4'd6,
        OP_LOAD_COLOR  = 4'd7,
        OP_LOAD_MASK   = 4'd8
    } op_e;

    typedef struct packed {
        logic [PIX_W-1:0] value;
        logic [PIX_W-1:0] planes;
    } plane_src_t;

    function automatic logic [PIX_W-1:0] plane_merge(
        input logic [PIX_W-1:0] old_v,
        input plane_src_t       src
    );
        return (old_v & ~src.planes) | (src.value & src.planes);
    endfunction

    function automatic op_e decode_op(input logic [3:0] code);
        return (code > 4'd8) ? OP_IDLE : op_e'(code);
    endfunction
endpackage

// File: rtl/mwd_regs.sv
module mwd_regs
    import mwd_pkg::*;
#(
    parameter int ROW_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic              held,
    input  logic [ROW_AW-1:0] row,
    input  logic [PIX_W-1:0]  data,
    output logic [PIX_W-1:0]  color_q,
    output logic [PIX_W-1:0]  page_mask_q,
    output logic [ROW_AW-1:0] page_row_q,
    output logic [PIX_W-1:0]  flash_mask
);
    logic [PIX_W-1:0] held_mask_q;
    logic [PIX_W-1:0] chosen_mask;

    assign chosen_mask = held ? held_mask_q : data;
    assign flash_mask  = chosen_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            color_q     <= '0;
            held_mask_q <= '1;
            page_mask_q <= '1;
            page_row_q  <= '0;
        end else begin
            unique case (op)
                OP_OPEN_PLAIN: begin
                    page_row_q  <= row;
                    page_mask_q <= '1;
                end
                OP_OPEN_MASKED: begin
                    page_row_q  <= row;
                    page_mask_q <= chosen_mask;
                end
                OP_LOAD_COLOR: color_q     <= data;
                OP_LOAD_MASK:  held_mask_q <= data;
                default: ;
            endcase
        end
    end

    assert_color_load_R7: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD_COLOR |=> color_q == $past(data));
    assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD_MASK |=> held_mask_q == $past(data));
    assert_plain_page_R8: assert property (@(posedge clk) disable iff (rst)
        op == OP_OPEN_PLAIN |=> page_mask_q == '1);
    assert_held_page_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_OPEN_MASKED && held) |=> page_mask_q == $past(held_mask_q));
    assert_bus_page_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_OPEN_MASKED && !held) |=> page_mask_q == $past(data));
    assert_flash_keeps_page_R10: assert property (@(posedge clk) disable iff (rst)
        op == OP_FLASH |=> ($stable(page_mask_q) && $stable(page_row_q)));
endmodule

// File: rtl/mwd_array.sv
module mwd_array
    import mwd_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  op_e                      op,
    input  logic [$clog2(ROWS)-1:0]  page_row,
    input  logic [PIX_W-1:0]         page_mask,
    input  logic [$clog2(ROWS)-1:0]  flash_row,
    input  logic [PIX_W-1:0]         flash_mask,
    input  logic [$clog2(COLS)-1:0]  col,
    input  logic [PIX_W-1:0]         data,
    input  logic [PIX_W-1:0]         color,
    output logic [PIX_W-1:0]         rd_data
);
    localparam int ROW_AW = $clog2(ROWS);
    localparam int COL_AW = $clog2(COLS);
    localparam int GRP_W  = COL_AW - BLOCK_SH;

    logic [PIX_W-1:0] mem [ROWS][COLS];

    logic [GRP_W-1:0] grp;
    plane_src_t       pix_src, blk_src, fl_src;
    logic [PIX_W-1:0] flash_next [COLS];
    logic [PIX_W-1:0] blk_next   [BLOCK_COLS];
    logic [PIX_W-1:0] cur_word;
    logic [PIX_W-1:0] first_word;

    assign grp        = col[COL_AW-1:BLOCK_SH];
    assign pix_src    = '{value: data,  planes: page_mask};
    assign blk_src    = '{value: color, planes: page_mask};
    assign fl_src     = '{value: color, planes: flash_mask};
    assign cur_word   = mem[page_row][col];
    assign first_word = mem[page_row][0];

    for (genvar c = 0; c < COLS; c++) begin : g_flash_lane
        assign flash_next[c] = plane_merge(mem[flash_row][c], fl_src);
    end

    for (genvar k = 0; k < BLOCK_COLS; k++) begin : g_block_lane
        assign blk_next[k] = plane_merge(mem[page_row][{grp, BLOCK_SH'(k)}], blk_src);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    mem[r][c] <= '0;
        end else begin
            unique case (op)
                OP_READ:  rd_data <= cur_word;
                OP_WRITE: mem[page_row][col] <= plane_merge(cur_word, pix_src);
                OP_BLOCK: begin
                    for (int k = 0; k < BLOCK_COLS; k++)
                        if (data[k])
                            mem[page_row][{grp, BLOCK_SH'(k)}] <= blk_next[k];
                end
                OP_FLASH: begin
                    for (int c = 0; c < COLS; c++)
                        mem[flash_row][c] <= flash_next[c];
                end
                default: ;
            endcase
        end
    end

    assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
        op != OP_READ |=> $stable(rd_data));
    assert_masked_planes_kept_R4: assert property (@(posedge clk) disable iff (rst)
        op == OP_WRITE |=>
        ((mem[$past(page_row)][$past(col)] ^ $past(cur_word)) & ~$past(page_mask)) == '0);
    assert_block_outside_group_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BLOCK && grp != '0) |=> mem[$past(page_row)][0] == $past(first_word));
    assert_flash_first_col_R10: assert property (@(posedge clk) disable iff (rst)
        op == OP_FLASH |=> mem[$past(flash_row)][0] == $past(flash_next[0]));
endmodule

// File: rtl/masked_fill_datapath.sv
module masked_fill_datapath
    import mwd_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [3:0]               op_i,
    input  logic                     held_mask_i,
    input  logic [$clog2(ROWS)-1:0]  row_i,
    input  logic [$clog2(COLS)-1:0]  col_i,
    input  logic [PIX_W-1:0]         data_i,
    output logic [PIX_W-1:0]         rd_data_o
);
    localparam int ROW_AW = $clog2(ROWS);

    op_e               op;
    logic [PIX_W-1:0]  color_q;
    logic [PIX_W-1:0]  page_mask_q;
    logic [ROW_AW-1:0] page_row_q;
    logic [PIX_W-1:0]  flash_mask;

    assign op = decode_op(op_i);

    mwd_regs #(.ROW_AW(ROW_AW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .held        (held_mask_i),
        .row         (row_i),
        .data        (data_i),
        .color_q     (color_q),
        .page_mask_q (page_mask_q),
        .page_row_q  (page_row_q),
        .flash_mask  (flash_mask)
    );

    mwd_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .page_row   (page_row_q),
        .page_mask  (page_mask_q),
        .flash_row  (row_i),
        .flash_mask (flash_mask),
        .col        (col_i),
        .data       (data_i),
        .color      (color_q),
        .rd_data    (rd_data_o)
    );

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        op == OP_IDLE |=> ($stable(color_q) && $stable(page_mask_q) && $stable(rd_data_o)));
endmodule

// File: tb/tb_masked_fill_datapath.sv
module tb_masked_fill_datapath;
    localparam int ROWS = 8;
    localparam int COLS = 16;
    localparam int RAW  = $clog2(ROWS);
    localparam int CAW  = $clog2(COLS);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [3:0]     op_i = '0;
    logic           held_mask_i = 1'b0;
    logic [RAW-1:0] row_i = '0;
    logic [CAW-1:0] col_i = '0;
    logic [7:0]     data_i = '0;
    logic [7:0]     rd_data_o;

    always #10 clk = ~clk;

    masked_fill_datapath #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk(clk), .rst(rst), .op_i(op_i), .held_mask_i(held_mask_i),
        .row_i(row_i), .col_i(col_i), .data_i(data_i), .rd_data_o(rd_data_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] sh [ROWS][COLS];
    logic [7:0] m_color, m_hmask, m_pmask;
    int         m_prow;
    logic [7:0] m_rd;

    function automatic logic [7:0] gate(input logic [7:0] o, input logic [7:0] n,
                                        input logic [7:0] m);
        logic [7:0] res;
        for (int b = 0; b < 8; b++) res[b] = m[b] ? n[b] : o[b];
        return res;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] o, input int r, input int c,
                         input logic [7:0] d, input logic h, input string tag);
        logic [7:0] fm;
        @(negedge clk);
        op_i = o; row_i = RAW'(r); col_i = CAW'(c); data_i = d; held_mask_i = h;
        @(posedge clk);
        #1;
        op_i = '0;
        case (o)
            4'd1: begin m_prow = r; m_pmask = 8'hFF; end
            4'd2: begin m_prow = r; m_pmask = h ? m_hmask : d; end
            4'd3: m_rd = sh[m_prow][c];
            4'd4: sh[m_prow][c] = gate(sh[m_prow][c], d, m_pmask);
            4'd5: for (int k = 0; k < 4; k++)
                      if (d[k]) sh[m_prow][(c & ~3) + k] = gate(sh[m_prow][(c & ~3) + k], m_color, m_pmask);
            4'd6: begin
                fm = h ? m_hmask : d;
                for (int k = 0; k < COLS; k++) sh[r][k] = gate(sh[r][k], m_color, fm);
            end
            4'd7: m_color = d;
            4'd8: m_hmask = d;
            default: ;
        endcase
        if (o == 4'd3) check(rd_data_o, m_rd, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) sh[r][c] = 8'h00;
        m_color = 8'h00; m_hmask = 8'hFF; m_pmask = 8'hFF; m_prow = 0; m_rd = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check(rd_data_o, 8'h00, "R1 rd_data after reset");

        // R1: array and colour start at zero; held mask all ones
        issue(4'd1, 2, 0, 8'h00, 0, "R8");
        issue(4'd3, 2, 5, 8'h00, 0, "R1 array zero");
        issue(4'd5, 2, 0, 8'h01, 0, "R1");
        issue(4'd3, 2, 0, 8'h00, 0, "R1 colour zero");
        issue(4'd6, 3, 0, 8'h00, 1, "R1");
        issue(4'd1, 3, 0, 8'h00, 0, "R8");
        issue(4'd3, 3, 9, 8'h00, 0, "R1 held mask ones");

        // R7 then R9: colour load followed at once by block fill, low col bits ignored
        issue(4'd1, 2, 0, 8'h00, 0, "R8");
        issue(4'd7, 0, 0, 8'h5A, 0, "R7");
        issue(4'd5, 2, 6, 8'h0A, 0, "R9");
        for (int c = 4; c < 8; c++) issue(4'd3, 2, c, 8'h00, 0, "R9 block columns");
        issue(4'd3, 2, 8, 8'h00, 0, "R9 outside group");

        // R3 plain write, R5 new mask held over the page, R4 plane gating
        issue(4'd4, 2, 0, 8'h3C, 0, "R3");
        issue(4'd3, 2, 0, 8'h00, 0, "R3 plain write");
        issue(4'd2, 2, 0, 8'h0F, 0, "R5");
        issue(4'd4, 2, 0, 8'hFF, 0, "R5");
        issue(4'd4, 2, 1, 8'hAA, 0, "R4");
        issue(4'd3, 2, 0, 8'h00, 0, "R5 bus mask");
        issue(4'd3, 2, 1, 8'h00, 0, "R4 planes kept");

        // R6 held mask, bus ignored
        issue(4'd8, 0, 0, 8'hF0, 0, "R7");
        issue(4'd2, 3, 0, 8'h0F, 1, "R6");
        issue(4'd4, 3, 2, 8'hFF, 0, "R6");
        issue(4'd3, 3, 2, 8'h00, 0, "R6 held mask");

        // R10 flash fills, bus mask and held mask, page kept
        issue(4'd6, 4, 0, 8'h33, 0, "R10");
        issue(4'd4, 3, 3, 8'hFF, 0, "R10 page kept");
        issue(4'd3, 3, 3, 8'h00, 0, "R10 page mask after flash");
        issue(4'd6, 3, 0, 8'hFF, 1, "R10 flash open row");
        issue(4'd3, 3, 2, 8'h00, 0, "R10 open row flashed");
        issue(4'd1, 4, 0, 8'h00, 0, "R8");
        issue(4'd3, 4, 0, 8'h00, 0, "R10 first column");
        issue(4'd3, 4, COLS-1, 8'h00, 0, "R10 last column");

        // R11 unused codes and idle leave everything unchanged
        issue(4'd12, 4, 0, 8'hFF, 0, "R11");
        issue(4'd0, 4, 0, 8'hFF, 1, "R11");
        check(rd_data_o, m_rd, "R11 rd_data held");
        issue(4'd3, 4, 0, 8'h00, 0, "R11 array unchanged");

        // random mix
        for (int i = 0; i < 800; i++) begin
            int sel;
            logic [3:0] o;
            sel = $urandom_range(0, 19);
            if (sel < 2)       o = 4'd1;
            else if (sel < 4)  o = 4'd2;
            else if (sel < 8)  o = 4'd3;
            else if (sel < 12) o = 4'd4;
            else if (sel < 15) o = 4'd5;
            else if (sel < 16) o = 4'd6;
            else if (sel < 17) o = 4'd7;
            else if (sel < 18) o = 4'd8;
            else if (sel < 19) o = 4'd0;
            else               o = 4'(9 + $urandom_range(0, 6));
            issue(o, $urandom_range(0, ROWS-1), $urandom_range(0, COLS-1),
                  8'($urandom), 1'($urandom), "R2 random read");
        end

        // final sweep of the whole array
        for (int r = 0; r < ROWS; r++) begin
            issue(4'd1, r, 0, 8'h00, 0, "R8");
            for (int c = 0; c < COLS; c++) issue(4'd3, r, c, 8'h00, 0, "R2 R11 sweep");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule